// File: doc/BRIEF.md
# Serial Configuration Stream Loader

This block sits on a serial configuration chain and takes one bit of configuration data per clock. It watches the incoming stream for a four-bit start code, then collects a 24-bit length count. It then runs a load phase of exactly that many clocks. In that phase it splits the stream into frames, checks the closing field of each frame and writes every good frame's payload to a configuration-memory write port.

The block acts as a pass-through node in a daisy chain. While it hunts for the start code and takes in the length count, its chain output repeats the input one clock later, so the next device sees the same header. During its own load it holds the chain output high, so no frame start bit can reach the devices further down. After the load it runs four finishing clocks and then gives a single-cycle done pulse. From then on it forwards the stream again, so the remaining bits reach the next device. A bad frame stops the load for good. The active-low error flag is pulled down and stays down until reset.

Top module: `cfg_stream_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chain_dout is 1, err_n is 1, load_done is 0, mem_we is 0 and mem_addr is 0.
- R2: The header starts only when the last four input bits, oldest first, are 0,0,1,0. A stream that never contains that window keeps the block in its hunt phase, and chain_dout keeps following the input.
- R3: During the hunt and during the 24 length bits, chain_dout equals the cfg_din bit sampled at the previous clock edge.
- R4: The 24 bits that follow the start code form the length count, most significant bit first. The load phase then lasts exactly that many clocks, and chain_dout is 1 throughout it.
- R5: Inside the load phase, 1 bits between frames are ignored. A 0 bit starts a frame. It is followed by FRAME_BITS data bits (most significant first) and a 4-bit check field that is correct when it reads 0,1,1,0 in arrival order.
- R6: A frame with a correct check field raises mem_we for exactly one cycle, in the cycle after its last check bit. mem_data carries the frame payload. mem_addr is 0 for the first frame after reset and rises by one for each frame written.
- R7: A frame with a wrong check field drives err_n to 0 in the cycle after its last check bit. From then until reset, err_n stays 0, mem_we stays 0, chain_dout stays 1 and load_done never rises.
- R8: A frame that has not received its last check bit when the load phase ends is dropped, and no write occurs for it.
- R9: After the load phase, four more clocks follow with chain_dout at 1. load_done is 1 for exactly one cycle, the cycle after the fourth of those clocks.
- R10: From the clock edge after the done pulse, chain_dout again equals the cfg_din bit sampled at the previous edge.
- R11: A length count of zero skips the load phase, and the four finishing clocks start straight after the last length bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_din | input | 1 | Serial configuration data in |
| chain_dout | output | 1 | Daisy-chain data out to the next device |
| mem_we | output | 1 | Configuration-memory write strobe |
| mem_addr | output | ADDR_W | Frame address of the write |
| mem_data | output | FRAME_BITS | Frame payload written |
| err_n | output | 1 | Active-low sticky frame-error flag |
| load_done | output | 1 | Single-cycle load-complete pulse |

## Verification
Each internal fault shows up at a port within a few clocks. A missed or false start code shows up about 25 clocks later, when chain_dout either fails to go high or goes high when it should not. A drift in the length counter moves the done pulse, or makes chain_dout start forwarding one clock early or late. A frame parser that is out of step produces a write with the wrong payload, a missing or spurious mem_we, or a false err_n, in the cycle after the frame's last bit. A lost error state is visible as soon as a later frame writes or the done pulse appears.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

    localparam int          PRE_W     = 4;
    localparam logic [3:0]  PRE_CODE  = 4'b0010;
    localparam int          LEN_W     = 24;
    localparam int          CHK_W     = 4;
    localparam logic [3:0]  CHK_CODE  = 4'b0110;
    localparam int          FIN_CLKS  = 4;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_LOAD,
        ST_FIN,
        ST_PASS,
        ST_HALT
    } ldr_state_e;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_DATA,
        FR_CHK
    } frame_state_e;

    typedef enum logic {
        HD_HUNT,
        HD_LEN
    } hdr_state_e;

    function automatic logic [PRE_W-1:0] push_hist(input logic [PRE_W-1:0] h,
                                                   input logic b);
        return {h[PRE_W-2:0], b};
    endfunction

    function automatic logic chk_ok(input logic [CHK_W-1:0] c);
        return c == CHK_CODE;
    endfunction

endpackage

// File: rtl/cfg_hdr_rx.sv
module cfg_hdr_rx
    import cfg_ldr_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          din,
    output logic          fire,
    output logic [LW-1:0] len_val
);
    localparam int BC_W = $clog2(LW);

    hdr_state_e       st_q;
    logic [PRE_W-1:0] hist_q;
    logic [PRE_W-1:0] hist_nx;
    logic [BC_W-1:0]  bcnt_q;
    logic [LW-1:0]    len_q;
    logic             len_last;

    assign hist_nx  = push_hist(hist_q, din);
    assign len_last = (bcnt_q == BC_W'(LW - 1));
    assign len_val  = {len_q[LW-2:0], din};
    assign fire     = en && (st_q == HD_LEN) && len_last;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st_q   <= HD_HUNT;
            hist_q <= '1;
            bcnt_q <= '0;
            len_q  <= '0;
        end else begin
            case (st_q)
                HD_HUNT: begin
                    hist_q <= hist_nx;
                    if (hist_nx == PRE_CODE) begin
                        st_q   <= HD_LEN;
                        bcnt_q <= '0;
                    end
                end
                HD_LEN: begin
                    len_q  <= len_val;
                    bcnt_q <= bcnt_q + 1'b1;
                    if (len_last) begin
                        st_q   <= HD_HUNT;
                        hist_q <= '1;
                    end
                end
                default: st_q <= HD_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
    import cfg_ldr_pkg::*;
#(
    parameter int DW = 64,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          din,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          bad
);
    localparam int IDX_MAX = (DW > CHK_W) ? DW : CHK_W;
    localparam int IDX_W   = $clog2(IDX_MAX);

    frame_state_e     st_q;
    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    data_q;
    logic [CHK_W-2:0] chk_q;
    logic [AW-1:0]    addr_q;
    logic [CHK_W-1:0] chk_full;
    logic             chk_last;
    logic             good;

    assign chk_full = {chk_q, din};
    assign chk_last = en && (st_q == FR_CHK) && (idx_q == IDX_W'(CHK_W - 1));
    assign good     = chk_last && chk_ok(chk_full);
    assign bad      = chk_last && !chk_ok(chk_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FR_IDLE;
            idx_q   <= '0;
            data_q  <= '0;
            chk_q   <= '0;
            addr_q  <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (!en) begin
                st_q  <= FR_IDLE;
                idx_q <= '0;
            end else begin
                case (st_q)
                    FR_IDLE: begin
                        if (!din) begin
                            st_q  <= FR_DATA;
                            idx_q <= '0;
                        end
                    end
                    FR_DATA: begin
                        data_q <= {data_q[DW-2:0], din};
                        if (idx_q == IDX_W'(DW - 1)) begin
                            st_q  <= FR_CHK;
                            idx_q <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                    FR_CHK: begin
                        chk_q <= chk_full[CHK_W-2:0];
                        if (chk_last) begin
                            st_q  <= FR_IDLE;
                            idx_q <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                        if (good) begin
                            wr_en   <= 1'b1;
                            wr_addr <= addr_q;
                            wr_data <= data_q;
                            addr_q  <= addr_q + 1'b1;
                        end
                    end
                    default: st_q <= FR_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_len_ctr.sv
module cfg_len_ctr #(
    parameter int LW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [LW-1:0] len,
    output logic          hit
);
    logic [LW-1:0] cnt_q;
    logic [LW-1:0] cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;
    assign hit     = en && (cnt_inc == len);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_inc;
    end
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
    import cfg_ldr_pkg::*;
#(
    parameter int FRAME_BITS = 64,
    parameter int ADDR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_din,
    output logic                  chain_dout,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [FRAME_BITS-1:0] mem_data,
    output logic                  err_n,
    output logic                  load_done
);
    localparam int FIN_W = $clog2(FIN_CLKS);

    ldr_state_e       st_q;
    logic [LEN_W-1:0] len_q;
    logic [FIN_W-1:0] fin_q;
    logic             hdr_fire;
    logic [LEN_W-1:0] hdr_len;
    logic             in_hdr;
    logic             in_load;
    logic             len_hit;
    logic             fr_bad;

    assign in_hdr  = (st_q == ST_HDR);
    assign in_load = (st_q == ST_LOAD);

    cfg_hdr_rx #(.LW(LEN_W)) u_hdr (
        .clk     (clk),
        .rst     (rst),
        .en      (in_hdr),
        .din     (cfg_din),
        .fire    (hdr_fire),
        .len_val (hdr_len)
    );

    cfg_len_ctr #(.LW(LEN_W)) u_ctr (
        .clk (clk),
        .rst (rst),
        .clr (hdr_fire),
        .en  (in_load),
        .len (len_q),
        .hit (len_hit)
    );

    cfg_frame_rx #(.DW(FRAME_BITS), .AW(ADDR_W)) u_frm (
        .clk     (clk),
        .rst     (rst),
        .en      (in_load),
        .din     (cfg_din),
        .wr_en   (mem_we),
        .wr_addr (mem_addr),
        .wr_data (mem_data),
        .bad     (fr_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_HDR;
            len_q      <= '0;
            fin_q      <= '0;
            chain_dout <= 1'b1;
            err_n      <= 1'b1;
            load_done  <= 1'b0;
        end else begin
            load_done <= 1'b0;
            case (st_q)
                ST_HDR: begin
                    chain_dout <= cfg_din;
                    if (hdr_fire) begin
                        len_q <= hdr_len;
                        fin_q <= '0;
                        st_q  <= (hdr_len == '0) ? ST_FIN : ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    chain_dout <= 1'b1;
                    if (fr_bad) begin
                        st_q  <= ST_HALT;
                        err_n <= 1'b0;
                    end else if (len_hit) begin
                        st_q  <= ST_FIN;
                        fin_q <= '0;
                    end
                end
                ST_FIN: begin
                    chain_dout <= 1'b1;
                    fin_q      <= fin_q + 1'b1;
                    if (fin_q == FIN_W'(FIN_CLKS - 1)) begin
                        st_q      <= ST_PASS;
                        load_done <= 1'b1;
                    end
                end
                ST_PASS: chain_dout <= cfg_din;
                default: chain_dout <= 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/cfg_stream_loader_chk.sv
module cfg_stream_loader_chk (
    input logic clk,
    input logic rst,
    input logic chain_dout,
    input logic mem_we,
    input logic err_n,
    input logic load_done
);
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !err_n |=> !err_n);

    // R7
    no_write_after_err_chk: assert property (@(posedge clk) disable iff (rst)
        !err_n |-> !mem_we);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        load_done |=> !load_done);

    // R7
    done_without_err_chk: assert property (@(posedge clk) disable iff (rst)
        load_done |-> err_n);

    // R6
    write_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R4
    dout_high_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> chain_dout);
endmodule

bind cfg_stream_loader cfg_stream_loader_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .chain_dout (chain_dout),
    .mem_we     (mem_we),
    .err_n      (err_n),
    .load_done  (load_done)
);

// File: tb/sim_cfg_stream_loader.sv
module sim_cfg_stream_loader;
    localparam int FB = 16;
    localparam int AW = 6;
    localparam int NV = 6;
    localparam int FR_LEN = 1 + FB + 4;

    // each entry: {idle ones before frame [1:0], payload [15:0]}
    localparam logic [17:0] VEC [0:NV-1] = '{
        {2'd0, 16'hA5C3}, {2'd2, 16'h0001}, {2'd1, 16'h8000},
        {2'd0, 16'hFFFF}, {2'd3, 16'h0000}, {2'd1, 16'h3C96}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          din = 1'b1;
    logic          dout, we, err_n, done;
    logic [AW-1:0] addr;
    logic [FB-1:0] data;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            finished = 0;

    always #4 clk = ~clk;

    cfg_stream_loader #(.FRAME_BITS(FB), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cfg_din(din), .chain_dout(dout),
        .mem_we(we), .mem_addr(addr), .mem_data(data),
        .err_n(err_n), .load_done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(input logic b);
        din = b;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        din = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 dout", 32'(dout), 1);
        check("R1 err_n", 32'(err_n), 1);
        check("R1 done", 32'(done), 0);
        check("R1 we", 32'(we), 0);
        rst = 1'b0;
        send(1'b1);
        check("R1 addr", 32'(addr), 0);
        check("R1 we after release", 32'(we), 0);
    endtask

    task automatic send_header(input logic [23:0] len);
        send(1'b1);
        send(1'b1);
        for (int i = 3; i >= 0; i--) begin
            send(cfg_ldr_pkg::PRE_CODE[i]);
            check("R3 preamble passthrough", 32'(dout), 32'(cfg_ldr_pkg::PRE_CODE[i]));
        end
        for (int i = 23; i >= 0; i--) begin
            send(len[i]);
            check("R3 length passthrough", 32'(dout), 32'(len[i]));
        end
    endtask

    task automatic send_frame(input logic [FB-1:0] d, input logic [3:0] c);
        send(1'b0);
        check("R4 dout high on start bit", 32'(dout), 1);
        for (int i = FB - 1; i >= 0; i--) begin
            send(d[i]);
            check("R5 no write mid-frame", 32'(we), 0);
        end
        for (int i = 3; i >= 0; i--) send(c[i]);
    endtask

    task automatic finish_clocks(input string tag);
        for (int k = 0; k < 4; k++) begin
            send(1'b0);
            check({tag, " R9 dout high in finish"}, 32'(dout), 1);
            check({tag, " R9 done timing"}, 32'(done), (k == 3) ? 1 : 0);
            check({tag, " R8 no write in finish"}, 32'(we), 0);
        end
        send(1'b1);
        check({tag, " R9 done one cycle"}, 32'(done), 0);
        check({tag, " R10 follow 1"}, 32'(dout), 1);
        send(1'b0);
        check({tag, " R10 follow 0"}, 32'(dout), 0);
        send(1'b1);
        check({tag, " R10 follow 1 again"}, 32'(dout), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int total;
        @(negedge clk);

        // table-driven run of good frames (R5, R6, R4, R9, R10)
        do_reset();
        total = 0;
        for (int i = 0; i < NV; i++) total += int'(VEC[i][17:16]) + FR_LEN;
        send_header(24'(total));
        for (int i = 0; i < NV; i++) begin
            for (int g = 0; g < int'(VEC[i][17:16]); g++) begin
                send(1'b1);
                check("R5 idle ones ignored", 32'(we), 0);
                check("R4 dout high in load", 32'(dout), 1);
            end
            send_frame(VEC[i][15:0], 4'b0110);
            check("R6 write strobe", 32'(we), 1);
            check("R6 write data", 32'(data), 32'(VEC[i][15:0]));
            check("R6 write address", 32'(addr), i);
            check("R7 err_n stays high", 32'(err_n), 1);
        end
        finish_clocks("table");

        // R2: no start code in stream keeps forwarding
        do_reset();
        begin
            logic [7:0] pat = 8'b1011_0011;
            for (int i = 7; i >= 0; i--) begin
                send(pat[i]);
                check("R2 hunt passthrough", 32'(dout), 32'(pat[i]));
            end
            for (int i = 0; i < 30; i++) begin
                send(1'b0);
                check("R2 no false header", 32'(dout), 0);
            end
        end

        // R7: bad check field halts loading
        do_reset();
        send_header(24'd100);
        send_frame(16'h1234, 4'b0110);
        check("R6 first write", 32'(we), 1);
        check("R6 first addr", 32'(addr), 0);
        send_frame(16'h5678, 4'b0111);
        check("R7 err_n low", 32'(err_n), 0);
        check("R7 no write on bad frame", 32'(we), 0);
        send_frame(16'h9ABC, 4'b0110);
        check("R7 no write after error", 32'(we), 0);
        for (int i = 0; i < 40; i++) begin
            send(1'b0);
            check("R7 err sticky", 32'(err_n), 0);
            check("R7 dout held high", 32'(dout), 1);
            check("R7 no done after error", 32'(done), 0);
            check("R7 no write", 32'(we), 0);
        end

        // R8: frame cut by end of length is dropped
        do_reset();
        send_header(24'd30);
        send_frame(16'h0F0F, 4'b0110);
        check("R8 full frame written", 32'(we), 1);
        check("R8 full frame data", 32'(data), 32'h0F0F);
        send(1'b0);
        for (int i = 0; i < 8; i++) begin
            send(1'b1);
            check("R8 partial frame no write", 32'(we), 0);
        end
        finish_clocks("partial");

        // R11: zero length skips load phase
        do_reset();
        send_header(24'd0);
        finish_clocks("R11 zero length");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule